// File: doc/BRIEF.md
# Capacity Extent Event Record Generator

This block turns a batch of capacity extent descriptors into dynamic capacity event records, one record per descriptor, and presents each record to the insert port of the event log. A batch opens with a start pulse that carries the event subtype, the number of extents and the device's current count of extents in use. The descriptors then arrive on a valid/ready stream, and each one leaves as a complete record on the log's valid/ready insert port in the same cycle. The block holds no record storage of its own.

Every record carries a header (a fixed event identifier, a class mask with only the informational class bit set, a fixed record length and the current device timestamp) and a body with the subtype, a validity field, zeroed host and region fields, the number of extents still available, a flags byte whose bit 0 chains the records of a batch, and the copied descriptor. When the log reports, with an accepted insert, that it went from empty to non-empty, the block raises a one-cycle interrupt request. A done pulse closes each batch.

Top module: `dc_extent_event_gen`

## Requirements
- R1: After reset rec_valid_o, ext_ready_o, irq_o, done_o and busy_o are all 0.
- R2: A batch of N extents produces exactly N records, in input order; rec_extent_o equals the descriptor on ext_data_i of the record being offered.
- R3: Bit 0 of rec_flags_o is 1 on every record of a batch except the last, where it is 0; bits 7:1 of rec_flags_o are always 0.
- R4: rec_vld_flags_o is 1, rec_host_o and rec_region_o are 0, and rec_subtype_o equals subtype_i as captured at the start pulse.
- R5: rec_avail_o equals the MAX_EXT parameter minus total_ext_i as captured at the start pulse.
- R6: rec_class_o has only bit INFO_BIT set, rec_id_o equals EVT_ID, rec_len_o equals REC_LEN, and rec_ts_o equals timestamp_i in the cycle the record is offered.
- R7: irq_o is a one-cycle pulse in the cycle after a record is accepted (rec_valid_o and rec_ready_i) with rec_first_i high; in every other cycle irq_o is 0.
- R8: While busy, ext_ready_o follows rec_ready_i and a descriptor offered while rec_ready_i is 0 is not consumed; while idle, ext_ready_o and rec_valid_o are 0 whatever ext_valid_i does.
- R9: done_o is a one-cycle pulse in the cycle after the last record of a batch is accepted, and busy_o is 0 from that same cycle.
- R10: A start pulse with ext_count_i of 0 emits no record, leaves busy_o at 0, and gives a done_o pulse in the next cycle.
- R11: A start pulse while busy_o is 1 is ignored: the running batch keeps its count, subtype and available-extents value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Opens a batch when idle |
| subtype_i | input | SUB_W | Event subtype for the batch |
| ext_count_i | input | CNT_W | Number of extents in the batch |
| total_ext_i | input | AVL_W | Extents currently in use |
| timestamp_i | input | TS_W | Current device timestamp |
| ext_valid_i | input | 1 | Descriptor valid |
| ext_data_i | input | EXT_W | Raw extent descriptor |
| ext_ready_o | output | 1 | Descriptor accepted |
| rec_valid_o | output | 1 | Record offered to the log |
| rec_ready_i | input | 1 | Log insert port ready |
| rec_first_i | input | 1 | Log went empty to non-empty on this insert |
| rec_id_o | output | ID_W | Header event identifier |
| rec_class_o | output | 8 | Header event class mask |
| rec_len_o | output | LEN_W | Header record length |
| rec_ts_o | output | TS_W | Header timestamp |
| rec_subtype_o | output | SUB_W | Event subtype |
| rec_vld_flags_o | output | 8 | Validity flags |
| rec_host_o | output | 16 | Host identifier |
| rec_region_o | output | 8 | Updated region identifier |
| rec_avail_o | output | AVL_W | Extents still available |
| rec_flags_o | output | 8 | Record flags, bit 0 = more records follow |
| rec_extent_o | output | EXT_W | Copied extent descriptor |
| irq_o | output | 1 | Interrupt request pulse |
| done_o | output | 1 | Batch complete pulse |
| busy_o | output | 1 | Batch in progress |

## Verification
The bench builds the block with CNT_W of 4, so a fifteen-extent batch, the largest count the port can carry, is reachable and walks the chaining flag across a long run. MAX_EXT is 32 with a 16-bit AVL_W, so an in-use count equal to the limit drives the available field to exactly zero. INFO_BIT is 0 and the identifier and length take distinctive values, so a wrong header constant shows up at once; a 32-bit timestamp that counts cycles makes a stale or early sample visible.

// File: rtl/dc_evt_pkg.sv
package dc_evt_pkg;
  localparam int unsigned FLAG_W   = 8;
  localparam int unsigned HOST_W   = 16;
  localparam int unsigned REGION_W = 8;
  localparam int unsigned CLASS_W  = 8;
  localparam logic [FLAG_W-1:0] VLD_FLAGS = 8'h01;
  localparam int unsigned MORE_BIT = 0;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } batch_st_e;
endpackage

// File: rtl/dc_batch_ctrl.sv
module dc_batch_ctrl
  import dc_evt_pkg::*;
#(
  parameter int unsigned CNT_W   = 8,
  parameter int unsigned SUB_W   = 8,
  parameter int unsigned AVL_W   = 16,
  parameter int unsigned MAX_EXT = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [SUB_W-1:0] subtype_i,
  input  logic [AVL_W-1:0] total_i,
  input  logic             fire_i,
  output logic             busy_o,
  output logic             last_o,
  output logic [SUB_W-1:0] subtype_o,
  output logic [AVL_W-1:0] avail_o,
  output logic             done_o
);
  localparam logic [AVL_W-1:0] MaxExt = AVL_W'(MAX_EXT);
  localparam logic [CNT_W-1:0] One    = CNT_W'(1);

  batch_st_e        st_q;
  logic [CNT_W-1:0] remain_q;
  logic [SUB_W-1:0] sub_q;
  logic [AVL_W-1:0] avail_q;
  logic             done_q;
  logic             launch;

  assign launch = (st_q == ST_IDLE) && start_i;
  assign last_o = (remain_q == One);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      remain_q <= '0;
      sub_q    <= '0;
      avail_q  <= '0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (launch) begin
        sub_q   <= subtype_i;
        avail_q <= MaxExt - total_i;
        if (count_i == '0) begin
          done_q <= 1'b1;
        end else begin
          remain_q <= count_i;
          st_q     <= ST_RUN;
        end
      end else if (st_q == ST_RUN && fire_i) begin
        remain_q <= remain_q - One;
        if (last_o) begin
          st_q   <= ST_IDLE;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o    = (st_q == ST_RUN);
  assign subtype_o = sub_q;
  assign avail_o   = avail_q;
  assign done_o    = done_q;
endmodule

// File: rtl/dc_rec_build.sv
module dc_rec_build
  import dc_evt_pkg::*;
#(
  parameter int unsigned EXT_W    = 64,
  parameter int unsigned ID_W     = 16,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned TS_W     = 32,
  parameter int unsigned INFO_BIT = 0,
  parameter logic [ID_W-1:0]  EVT_ID  = '0,
  parameter logic [LEN_W-1:0] REC_LEN = '0
) (
  input  logic                busy_i,
  input  logic                last_i,
  input  logic [TS_W-1:0]     ts_i,
  input  logic [EXT_W-1:0]    ext_i,
  output logic [ID_W-1:0]     id_o,
  output logic [CLASS_W-1:0]  class_o,
  output logic [LEN_W-1:0]    len_o,
  output logic [TS_W-1:0]     ts_o,
  output logic [FLAG_W-1:0]   vld_flags_o,
  output logic [HOST_W-1:0]   host_o,
  output logic [REGION_W-1:0] region_o,
  output logic [FLAG_W-1:0]   flags_o,
  output logic [EXT_W-1:0]    ext_o
);
  localparam logic [CLASS_W-1:0] ClassMask = CLASS_W'(1) << INFO_BIT;

  always_comb begin
    id_o        = EVT_ID;
    class_o     = ClassMask;
    len_o       = REC_LEN;
    ts_o        = ts_i;
    vld_flags_o = VLD_FLAGS;
    host_o      = '0;
    region_o    = '0;
    flags_o     = '0;
    flags_o[MORE_BIT] = busy_i && !last_i;
    ext_o       = ext_i;
  end
endmodule

// File: rtl/dc_irq_gen.sv
module dc_irq_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic first_i,
  output logic irq_o
);
  logic irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= fire_i && first_i;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/dc_extent_event_gen.sv
module dc_extent_event_gen
  import dc_evt_pkg::*;
#(
  parameter int unsigned EXT_W    = 64,
  parameter int unsigned CNT_W    = 8,
  parameter int unsigned SUB_W    = 8,
  parameter int unsigned AVL_W    = 16,
  parameter int unsigned TS_W     = 32,
  parameter int unsigned ID_W     = 16,
  parameter int unsigned LEN_W    = 8,
  parameter int unsigned MAX_EXT  = 16,
  parameter int unsigned INFO_BIT = 0,
  parameter logic [ID_W-1:0]  EVT_ID  = 16'hCAFE,
  parameter logic [LEN_W-1:0] REC_LEN = 8'h80
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [SUB_W-1:0] subtype_i,
  input  logic [CNT_W-1:0] ext_count_i,
  input  logic [AVL_W-1:0] total_ext_i,
  input  logic [TS_W-1:0]  timestamp_i,
  input  logic             ext_valid_i,
  input  logic [EXT_W-1:0] ext_data_i,
  output logic             ext_ready_o,
  output logic             rec_valid_o,
  input  logic             rec_ready_i,
  input  logic             rec_first_i,
  output logic [ID_W-1:0]  rec_id_o,
  output logic [7:0]       rec_class_o,
  output logic [LEN_W-1:0] rec_len_o,
  output logic [TS_W-1:0]  rec_ts_o,
  output logic [SUB_W-1:0] rec_subtype_o,
  output logic [7:0]       rec_vld_flags_o,
  output logic [15:0]      rec_host_o,
  output logic [7:0]       rec_region_o,
  output logic [AVL_W-1:0] rec_avail_o,
  output logic [7:0]       rec_flags_o,
  output logic [EXT_W-1:0] rec_extent_o,
  output logic             irq_o,
  output logic             done_o,
  output logic             busy_o
);
  logic busy, last, fire;

  assign fire        = busy && ext_valid_i && rec_ready_i;
  assign rec_valid_o = busy && ext_valid_i;
  assign ext_ready_o = busy && rec_ready_i;
  assign busy_o      = busy;

  dc_batch_ctrl #(
    .CNT_W(CNT_W), .SUB_W(SUB_W), .AVL_W(AVL_W), .MAX_EXT(MAX_EXT)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .count_i   (ext_count_i),
    .subtype_i (subtype_i),
    .total_i   (total_ext_i),
    .fire_i    (fire),
    .busy_o    (busy),
    .last_o    (last),
    .subtype_o (rec_subtype_o),
    .avail_o   (rec_avail_o),
    .done_o    (done_o)
  );

  dc_rec_build #(
    .EXT_W(EXT_W), .ID_W(ID_W), .LEN_W(LEN_W), .TS_W(TS_W),
    .INFO_BIT(INFO_BIT), .EVT_ID(EVT_ID), .REC_LEN(REC_LEN)
  ) u_build (
    .busy_i      (busy),
    .last_i      (last),
    .ts_i        (timestamp_i),
    .ext_i       (ext_data_i),
    .id_o        (rec_id_o),
    .class_o     (rec_class_o),
    .len_o       (rec_len_o),
    .ts_o        (rec_ts_o),
    .vld_flags_o (rec_vld_flags_o),
    .host_o      (rec_host_o),
    .region_o    (rec_region_o),
    .flags_o     (rec_flags_o),
    .ext_o       (rec_extent_o)
  );

  dc_irq_gen u_irq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .first_i (rec_first_i),
    .irq_o   (irq_o)
  );
endmodule

// File: rtl/dc_extent_event_gen_chk.sv
module dc_extent_event_gen_chk #(
  parameter int unsigned INFO_BIT = 0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_o,
  input logic       ext_valid_i,
  input logic       ext_ready_o,
  input logic       rec_valid_o,
  input logic       rec_ready_i,
  input logic       rec_first_i,
  input logic [7:0] rec_class_o,
  input logic [7:0] rec_vld_flags_o,
  input logic [15:0] rec_host_o,
  input logic [7:0] rec_region_o,
  input logic [7:0] rec_flags_o,
  input logic       irq_o,
  input logic       done_o
);
  assert_idle_quiet_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ext_ready_o && !rec_valid_o));

  assert_irq_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(rec_valid_o && rec_ready_i && rec_first_i));

  assert_irq_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_valid_o && rec_ready_i && rec_first_i) |=> irq_o);

  assert_flag_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_flags_o[7:1] == 7'd0));

  assert_fixed_fields_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> (rec_vld_flags_o == 8'd1 && rec_host_o == 16'd0 && rec_region_o == 8'd0));

  assert_class_mask_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_o |-> ($countones(rec_class_o) == 1 && rec_class_o[INFO_BIT]));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_done_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);

  assert_stall_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ext_valid_i && !rec_ready_i) |=> busy_o);
endmodule

bind dc_extent_event_gen dc_extent_event_gen_chk #(.INFO_BIT(INFO_BIT)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .busy_o          (busy_o),
  .ext_valid_i     (ext_valid_i),
  .ext_ready_o     (ext_ready_o),
  .rec_valid_o     (rec_valid_o),
  .rec_ready_i     (rec_ready_i),
  .rec_first_i     (rec_first_i),
  .rec_class_o     (rec_class_o),
  .rec_vld_flags_o (rec_vld_flags_o),
  .rec_host_o      (rec_host_o),
  .rec_region_o    (rec_region_o),
  .rec_flags_o     (rec_flags_o),
  .irq_o           (irq_o),
  .done_o          (done_o)
);

// File: tb/dc_extent_event_gen_tb_top.sv
`timescale 1ns/1ps
module dc_extent_event_gen_tb_top;
  localparam int unsigned EXT_W = 32, CNT_W = 4, SUB_W = 8, AVL_W = 16, TS_W = 32;
  localparam int unsigned ID_W = 16, LEN_W = 8, MAX_EXT = 32, INFO_BIT = 0;
  localparam logic [ID_W-1:0]  EVT_ID  = 16'hA5C3;
  localparam logic [LEN_W-1:0] REC_LEN = 8'h80;
  localparam int NVEC = 4;
  // {subtype[8], count[8], total[16], stall_mask[16], first_mask[16]}
  localparam logic [63:0] VEC [NVEC] = '{
    {8'h00, 8'd1,  16'd0,  16'h0000, 16'h0001},
    {8'h01, 8'd3,  16'd5,  16'h0002, 16'h0000},
    {8'h02, 8'd4,  16'd32, 16'h0009, 16'h0001},
    {8'h03, 8'd15, 16'd31, 16'h5555, 16'h0000}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, ext_valid = 1'b0, rec_ready = 1'b0, rec_first = 1'b0;
  logic [SUB_W-1:0] subtype = '0;
  logic [CNT_W-1:0] count = '0;
  logic [AVL_W-1:0] total = '0;
  logic [TS_W-1:0]  ts = '0;
  logic [EXT_W-1:0] ext_data = '0;
  logic ext_ready, rec_valid, irq, done, busy;
  logic [ID_W-1:0] rec_id;
  logic [7:0] rec_class, rec_vflags, rec_region, rec_flags;
  logic [LEN_W-1:0] rec_len;
  logic [TS_W-1:0] rec_ts;
  logic [SUB_W-1:0] rec_sub;
  logic [15:0] rec_host;
  logic [AVL_W-1:0] rec_avail;
  logic [EXT_W-1:0] rec_ext;
  int total_chk = 0, bad_chk = 0, cycles = 0;

  always #2 clk = ~clk;
  always @(posedge clk) begin
    ts <= ts + 1;
    cycles <= cycles + 1;
  end

  dc_extent_event_gen #(
    .EXT_W(EXT_W), .CNT_W(CNT_W), .SUB_W(SUB_W), .AVL_W(AVL_W), .TS_W(TS_W),
    .ID_W(ID_W), .LEN_W(LEN_W), .MAX_EXT(MAX_EXT), .INFO_BIT(INFO_BIT),
    .EVT_ID(EVT_ID), .REC_LEN(REC_LEN)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .subtype_i(subtype),
    .ext_count_i(count), .total_ext_i(total), .timestamp_i(ts),
    .ext_valid_i(ext_valid), .ext_data_i(ext_data), .ext_ready_o(ext_ready),
    .rec_valid_o(rec_valid), .rec_ready_i(rec_ready), .rec_first_i(rec_first),
    .rec_id_o(rec_id), .rec_class_o(rec_class), .rec_len_o(rec_len),
    .rec_ts_o(rec_ts), .rec_subtype_o(rec_sub), .rec_vld_flags_o(rec_vflags),
    .rec_host_o(rec_host), .rec_region_o(rec_region), .rec_avail_o(rec_avail),
    .rec_flags_o(rec_flags), .rec_extent_o(rec_ext), .irq_o(irq),
    .done_o(done), .busy_o(busy)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total_chk++;
    if (act !== exp) begin
      bad_chk++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic open_batch(input logic [7:0] s, input logic [CNT_W-1:0] n, input logic [15:0] t);
    subtype = s; count = n; total = t; start = 1'b1;
    step();
    start = 1'b0;
  endtask

  // offer one record; stall one cycle first if asked
  task automatic send(input logic [EXT_W-1:0] d, input bit stall, input bit first,
                      input bit is_last, input logic [7:0] s, input logic [15:0] av);
    ext_valid = 1'b1; ext_data = d; rec_first = first;
    if (stall) begin
      rec_ready = 1'b0;
      #1;
      chk("R8 stall ready", {63'd0, ext_ready}, 64'd0);
      step();
      chk("R7 no irq on stall", {63'd0, irq}, 64'd0);
      chk("R8 still busy", {63'd0, busy}, 64'd1);
    end
    rec_ready = 1'b1;
    #1;
    chk("R2 valid", {63'd0, rec_valid}, 64'd1);
    chk("R8 ready follows", {63'd0, ext_ready}, 64'd1);
    chk("R2 extent copy", 64'(rec_ext), 64'(d));
    chk("R3 more flag", 64'(rec_flags), is_last ? 64'd0 : 64'd1);
    chk("R4 fixed fields", {rec_vflags, rec_host, rec_region}, {8'd1, 16'd0, 8'd0});
    chk("R4 subtype", 64'(rec_sub), 64'(s));
    chk("R5 avail", 64'(rec_avail), 64'(av));
    chk("R6 header", {rec_id, rec_class, rec_len}, {EVT_ID, 8'h01, REC_LEN});
    chk("R6 timestamp", 64'(rec_ts), 64'(ts));
    step();
    ext_valid = 1'b0; rec_ready = 1'b0; rec_first = 1'b0;
    chk("R7 irq", {63'd0, irq}, {63'd0, first});
    chk("R9 done", {63'd0, done}, {63'd0, is_last});
    chk("R9 busy", {63'd0, busy}, {63'd0, !is_last});
  endtask

  initial begin
    wait (cycles > 100000);
    bad_chk++;
    $display("FAIL watchdog actual=%0d expected=<100000", cycles);
    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    chk("R1 reset", {59'd0, rec_valid, ext_ready, irq, done, busy}, 64'd0);
    rst_n = 1'b1;
    step();
    // R8: idle, descriptor offered, nothing happens
    ext_valid = 1'b1; rec_ready = 1'b1; rec_first = 1'b1;
    #1;
    chk("R8 idle quiet", {62'd0, rec_valid, ext_ready}, 64'd0);
    step();
    chk("R7 idle no irq", {63'd0, irq}, 64'd0);
    ext_valid = 1'b0; rec_ready = 1'b0; rec_first = 1'b0;

    for (int v = 0; v < NVEC; v++) begin
      logic [7:0] s; logic [7:0] n; logic [15:0] t, sm, fm;
      {s, n, t, sm, fm} = VEC[v];
      open_batch(s, CNT_W'(n), t);
      chk("R9 busy after start", {63'd0, busy}, 64'd1);
      for (int k = 0; k < int'(n); k++)
        send({8'(v), 8'(k), 16'hBEEF ^ 16'(k)}, sm[k], fm[k], k == int'(n) - 1,
             s, 16'(MAX_EXT) - t);
      step();
      chk("R9 done single", {63'd0, done}, 64'd0);
    end

    // R10: zero count
    open_batch(8'h44, '0, 16'd3);
    chk("R10 done", {62'd0, done, busy}, 64'd2);
    ext_valid = 1'b1; rec_ready = 1'b1;
    #1;
    chk("R10 no record", {63'd0, rec_valid}, 64'd0);
    step();
    ext_valid = 1'b0; rec_ready = 1'b0;
    chk("R10 done over", {63'd0, done}, 64'd0);

    // R11: start while busy ignored
    open_batch(8'h21, 4'd2, 16'd10);
    subtype = 8'h99; count = 4'd5; total = 16'd1; start = 1'b1;
    step();
    start = 1'b0;
    send(32'h1111_0000, 1'b0, 1'b0, 1'b0, 8'h21, 16'd22);
    send(32'h1111_0001, 1'b0, 1'b1, 1'b1, 8'h21, 16'd22);
    chk("R11 idle after two", {63'd0, busy}, 64'd0);

    $display("test done: total=%0d bad=%0d", total_chk, bad_chk);
    $finish;
  end
endmodule